// File: doc/BRIEF.md
# Paired Base Address Register Decoder

This block holds the base address registers of a configuration header and turns them into decoded base addresses that the device's address-range logic compares against. Configuration software writes whole or partial dwords through a register index, data and byte enables. A combinational read port returns the register contents. Software finds a region's size by writing all ones and reading the value back. The block then reports one 64-bit decoded base and a valid flag per register. A one-cycle pulse tells downstream range logic that a base has moved.

A register's read-only type field decides how it decodes. Bit 0 set means I/O space. Bits [2:1] equal to 2'b10 mean the register is the low half of a 64-bit memory base, and the next register supplies the upper 32 bits. Bits [2:1] equal to 2'b11 are reserved and decode as a plain 32-bit base. The upper half of a pair is a fully writable 32-bit register. Its own decoded slot always stays zero, so that it never claims an overlapping range. The pair's base is rebuilt in the low half's slot whichever half is written last.

Default layout, with index 0 first:
- Index 0: 64-bit memory low half, flags 4'h4, 4 KiB.
- Index 1: the upper half of index 0.
- Index 2: 32-bit prefetchable memory, flags 4'h8, 256 B.
- Index 3: I/O, flags 2'b01, 32 B.
- Index 4: reserved type, flags 4'h6, 64 KiB.
- Index 5: I/O wrongly flagged as 64-bit, flags 4'h5, 256 B.

Top module: `bar_decoder`

## Requirements
- R1: After reset, each register reads back only its read-only type bits (indices 0..5 give 0x4, 0x0, 0x8, 0x1, 0x6, 0x1). All decoded bases are zero, all valid flags are low, and no pulse is given. A valid flag falls only on reset.
- R2: Address bits below a region's size, and the read-only bits ([3:0] for memory, [1:0] for I/O), always read back as zero plus the type bits. Writing all ones to index 2 reads back 0xFFFFFF08. Only the bytes whose enables are set are updated.
- R3: A nonzero write to a plain 32-bit memory register does three things in the following cycle. Its decoded base becomes {32'h0, masked value}, its valid flag is set, and range_chg is high for exactly one cycle.
- R4: A write to the upper half of a pair (index 1) sets the low slot's base (slot 0) to {new upper value, stored masked low value}.
- R5: A write to the low half of a pair (index 0) sets slot 0 to {stored upper value, new masked low value}. This holds both when the upper half was written first and when it was written before an earlier low write.
- R6: The decoded slot of an upper half (slot 1) stays zero and its valid flag stays low.
- R7: A register whose type bits [2:1] read 2'b11 (index 4) decodes as a standalone 32-bit base.
- R8: An I/O register decodes as {32'h0, masked value}. If its bits [2:1] read 2'b10 (index 5), it still decodes as 32-bit I/O, and io_wide_err pulses for one cycle on each nonzero write.
- R9: A write whose masked value is zero still updates the register's read-back. It leaves the decoded base unchanged and gives no pulse.
- R10: range_chg pulses only when a decoded base or valid flag actually changes. Rewriting the same value gives no pulse.
- R11: A write to an index at or above the register count changes nothing, and a read of such an index returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_idx | input | IDX_W | Register index of the write |
| cfg_wr_data | input | 32 | Write data |
| cfg_wr_be | input | 4 | Byte enables of the write |
| cfg_rd_idx | input | IDX_W | Register index of the read |
| cfg_rd_data | output | 32 | Read-back of the indexed register |
| dec_base | output | NUM_BARS*64 | Decoded base per register, slot i at [i*64 +: 64] |
| dec_valid | output | NUM_BARS | Decoded base of slot i has been set |
| range_chg | output | 1 | One-cycle pulse after a decoded base changed |
| io_wide_err | output | 1 | One-cycle pulse after a nonzero write to an I/O register flagged 64-bit |

## Verification
The hardest situation to reach is a 64-bit pair rebuilt from a stale half. The bench writes the low half, then the upper half twice, then the low half again. Each step must merge with the value the other half already holds, so both orders and repeated rewrites are covered. A separate run after a mid-test reset writes the upper half into a pair whose low half is still zero. Zero-after-masking writes and exact rewrites are placed between real changes. This shows that the decoded base holds and the pulse stays quiet while the read-back still moves.

// File: rtl/bar_pkg.sv
// Package: shared helpers for the base address register decoder.
// Assumes 32-bit configuration dwords and 4-bit hard-wired type fields.
package bar_pkg;

    localparam int DW      = 32;
    localparam int BASE_W  = 64;
    localparam int FLAG_W  = 4;
    localparam int LOG2_W  = 6;

    typedef logic [BASE_W-1:0] base_t;

    // Address bits at or above the region size stay writable.
    function automatic logic [DW-1:0] size_mask(input int log2);
        return ~((32'h1 << log2) - 32'h1);
    endfunction

    // Bit 0 of the type field selects I/O space.
    function automatic logic is_io(input logic [FLAG_W-1:0] flags);
        return flags[0];
    endfunction

    // Type field 2'b10 marks a 64-bit decoder; 2'b11 is reserved.
    function automatic logic wide_type(input logic [FLAG_W-1:0] flags);
        return flags[2:1] == 2'b10;
    endfunction

    // Read-only bits returned on read-back.
    function automatic logic [DW-1:0] ro_bits(input logic [FLAG_W-1:0] flags);
        return is_io(flags) ? {30'b0, flags[1:0]} : {28'b0, flags};
    endfunction

    // Bits never stored because they are read-only.
    function automatic logic [DW-1:0] ro_mask(input logic [FLAG_W-1:0] flags);
        return is_io(flags) ? 32'hFFFF_FFFC : 32'hFFFF_FFF0;
    endfunction

endpackage

// File: rtl/bar_reg.sv
// Module: one base address register.
// Merges enabled bytes of a write into the stored address bits, drops
// bits below the region size and the read-only type bits, and returns
// the read-back word. An upper half of a pair keeps all 32 bits.
module bar_reg
    import bar_pkg::*;
#(
    parameter int                LOG2     = 12,
    parameter logic [FLAG_W-1:0] FLAGS    = 4'h0,
    parameter bit                IS_UPPER = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [DW-1:0] wr_data,
    input  logic [3:0]    wr_be,
    output logic [DW-1:0] addr_q,
    output logic [DW-1:0] addr_nxt,
    output logic [DW-1:0] rd_word
);

    localparam logic [DW-1:0] KEEP = IS_UPPER ? '1 : (size_mask(LOG2) & ro_mask(FLAGS));
    localparam logic [DW-1:0] RO   = IS_UPPER ? '0 : ro_bits(FLAGS);

    logic [DW-1:0] merged;

    // Byte-wise merge of write data over the stored value.
    for (genvar b = 0; b < 4; b++) begin : g_byte
        assign merged[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : addr_q[b*8 +: 8];
    end

    // Value stored if this write is accepted.
    always_comb addr_nxt = merged & KEEP;

    // Holds the writable address bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (wr_hit) addr_q <= addr_nxt;
    end

    // Read-back adds the hard-wired type bits.
    always_comb rd_word = addr_q | RO;

    // R11
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_hit) |-> $stable(addr_q));

endmodule

// File: rtl/bar_update_calc.sv
// Module: decides which decoded slot a write updates and with what.
// Assumes at most one write per cycle and index 0 first. A low half
// pairs with the next register; the pair's base lands in the low slot.
module bar_update_calc
    import bar_pkg::*;
#(
    parameter int                         NUM_BARS = 6,
    parameter int                         IDX_W    = 3,
    parameter logic [NUM_BARS*FLAG_W-1:0] FLAGS    = '0
) (
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [NUM_BARS-1:0][DW-1:0]   nxt_addr,
    input  logic [NUM_BARS-1:0][DW-1:0]   cur_addr,
    input  logic [NUM_BARS-1:0][BASE_W-1:0] cur_base,
    input  logic [NUM_BARS-1:0]           cur_valid,
    output logic                          upd,
    output logic [IDX_W-1:0]              upd_slot,
    output logic [BASE_W-1:0]             upd_base,
    output logic                          chg,
    output logic                          io_err
);

    logic [NUM_BARS-1:0] is_low;
    logic [NUM_BARS-1:0] is_up;
    logic [NUM_BARS-1:0] io_wide;

    // Roles are fixed by the type fields; the last register cannot pair.
    for (genvar i = 0; i < NUM_BARS; i++) begin : g_role
        localparam logic [FLAG_W-1:0] F = FLAGS[i*FLAG_W +: FLAG_W];
        assign io_wide[i] = is_io(F) && wide_type(F);
        if (i == NUM_BARS - 1) begin : g_last
            assign is_low[i] = 1'b0;
        end else begin : g_mid
            assign is_low[i] = !is_io(F) && wide_type(F) && !is_up[i];
        end
        if (i == 0) begin : g_first
            assign is_up[i] = 1'b0;
        end else begin : g_next
            assign is_up[i] = is_low[i-1];
        end
    end

    // Build the target slot and base for the current write.
    always_comb begin
        int          w;
        logic [DW-1:0] m;
        w        = int'(wr_idx);
        m        = '0;
        upd      = 1'b0;
        upd_slot = '0;
        upd_base = '0;
        io_err   = 1'b0;
        if (wr_en && w < NUM_BARS) begin
            m = nxt_addr[w];
            if (m != '0) begin
                upd = 1'b1;
                if (is_low[w]) begin
                    upd_slot = IDX_W'(w);
                    upd_base = {cur_addr[w+1], m};
                end else if (is_up[w]) begin
                    upd_slot = IDX_W'(w - 1);
                    upd_base = {m, cur_addr[w-1]};
                end else begin
                    upd_slot = IDX_W'(w);
                    upd_base = {32'h0, m};
                    io_err   = io_wide[w];
                end
            end
        end
    end

    // A pulse is due only if the slot's content actually moves.
    always_comb chg = upd && ((upd_base != cur_base[upd_slot]) || !cur_valid[upd_slot]);

endmodule

// File: rtl/bar_decoder.sv
// Module: top of the base address register decoder.
// Holds NUM_BARS registers, a decoded base and valid flag per slot, and
// registered change and error pulses. Writes and reads are one dword
// per cycle; reset is synchronous and active low.
module bar_decoder
    import bar_pkg::*;
#(
    parameter int                           NUM_BARS  = 6,
    parameter int                           IDX_W     = $clog2(NUM_BARS),
    parameter logic [NUM_BARS*LOG2_W-1:0]   BAR_LOG2  = {6'd8, 6'd16, 6'd5, 6'd8, 6'd0, 6'd12},
    parameter logic [NUM_BARS*FLAG_W-1:0]   BAR_FLAGS = {4'h5, 4'h6, 4'h1, 4'h8, 4'h0, 4'h4}
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr_en,
    input  logic [IDX_W-1:0]           cfg_wr_idx,
    input  logic [31:0]                cfg_wr_data,
    input  logic [3:0]                 cfg_wr_be,
    input  logic [IDX_W-1:0]           cfg_rd_idx,
    output logic [31:0]                cfg_rd_data,
    output logic [NUM_BARS*64-1:0]     dec_base,
    output logic [NUM_BARS-1:0]        dec_valid,
    output logic                       range_chg,
    output logic                       io_wide_err
);

    logic [NUM_BARS-1:0][DW-1:0]     addr_q;
    logic [NUM_BARS-1:0][DW-1:0]     addr_nxt;
    logic [NUM_BARS-1:0][DW-1:0]     rd_word;
    logic [NUM_BARS-1:0][BASE_W-1:0] dec_q;
    logic [NUM_BARS-1:0]             valid_q;
    logic                            range_chg_q;
    logic                            err_q;
    logic                            upd;
    logic [IDX_W-1:0]                upd_slot;
    logic [BASE_W-1:0]               upd_base;
    logic                            chg;
    logic                            io_err;

    // One register per index; upper halves keep all 32 bits.
    for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
        localparam logic [FLAG_W-1:0] F  = BAR_FLAGS[i*FLAG_W +: FLAG_W];
        localparam logic [FLAG_W-1:0] FP = (i == 0) ? 4'h0 : BAR_FLAGS[(i == 0 ? 0 : i-1)*FLAG_W +: FLAG_W];
        localparam bit UP = (i > 0) && (i - 1 < NUM_BARS - 1) && !is_io(FP) && wide_type(FP)
                            && !((i > 1) && !is_io(BAR_FLAGS[(i > 1 ? i-2 : 0)*FLAG_W +: FLAG_W])
                                 && wide_type(BAR_FLAGS[(i > 1 ? i-2 : 0)*FLAG_W +: FLAG_W]));
        logic hit;
        assign hit = cfg_wr_en && (int'(cfg_wr_idx) == i);
        bar_reg #(
            .LOG2     (int'(BAR_LOG2[i*LOG2_W +: LOG2_W])),
            .FLAGS    (F),
            .IS_UPPER (UP)
        ) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (hit),
            .wr_data  (cfg_wr_data),
            .wr_be    (cfg_wr_be),
            .addr_q   (addr_q[i]),
            .addr_nxt (addr_nxt[i]),
            .rd_word  (rd_word[i])
        );
    end

    bar_update_calc #(
        .NUM_BARS (NUM_BARS),
        .IDX_W    (IDX_W),
        .FLAGS    (BAR_FLAGS)
    ) u_calc (
        .wr_en     (cfg_wr_en),
        .wr_idx    (cfg_wr_idx),
        .nxt_addr  (addr_nxt),
        .cur_addr  (addr_q),
        .cur_base  (dec_q),
        .cur_valid (valid_q),
        .upd       (upd),
        .upd_slot  (upd_slot),
        .upd_base  (upd_base),
        .chg       (chg),
        .io_err    (io_err)
    );

    // Decoded bases, valid flags and the two pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q       <= '0;
            valid_q     <= '0;
            range_chg_q <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            range_chg_q <= chg;
            err_q       <= io_err;
            if (upd) begin
                dec_q[upd_slot]   <= upd_base;
                valid_q[upd_slot] <= 1'b1;
            end
        end
    end

    // Read-back mux; indices past the last register read zero.
    always_comb cfg_rd_data = (int'(cfg_rd_idx) < NUM_BARS) ? rd_word[cfg_rd_idx] : '0;

    assign dec_base    = dec_q;
    assign dec_valid   = valid_q;
    assign range_chg   = range_chg_q;
    assign io_wide_err = err_q;

    // R3
    pulse_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        range_chg |-> $past(cfg_wr_en));

    // R3
    move_signals_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dec_q) |-> range_chg);

    // R10
    pulse_needs_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        range_chg |-> (!$stable(dec_q) || !$stable(valid_q)));

    // R8
    err_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_wide_err |-> $past(cfg_wr_en));

    // R1
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(valid_q) & ~valid_q) == '0);

endmodule

// File: tb/tb_bar_decoder.sv
module tb_bar_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic [383:0] dec_base;
    logic [5:0]  dec_valid;
    logic        range_chg;
    logic        io_wide_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bar_decoder dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (wr_en),
        .cfg_wr_idx  (wr_idx),
        .cfg_wr_data (wr_data),
        .cfg_wr_be   (wr_be),
        .cfg_rd_idx  (rd_idx),
        .cfg_rd_data (rd_data),
        .dec_base    (dec_base),
        .dec_valid   (dec_valid),
        .range_chg   (range_chg),
        .io_wide_err (io_wide_err)
    );

    typedef struct packed {
        logic [2:0]  widx;
        logic [31:0] data;
        logic [3:0]  be;
        logic [31:0] rb;
        logic        pulse;
        logic        err;
        logic [2:0]  slot;
        logic [63:0] dec;
        logic        val;
        logic [3:0]  req;
    } vec_t;

    // Rows in order; each depends on the state left by the rows above.
    localparam vec_t VEC [13] = '{
        '{3'd2, 32'hFFFF_FFFF, 4'hF, 32'hFFFF_FF08, 1'b1, 1'b0, 3'd2, 64'h0000_0000_FFFF_FF00, 1'b1, 4'd2},  // R2 R3
        '{3'd2, 32'h1234_5678, 4'hF, 32'h1234_5608, 1'b1, 1'b0, 3'd2, 64'h0000_0000_1234_5600, 1'b1, 4'd3},  // R3
        '{3'd2, 32'h1234_5678, 4'hF, 32'h1234_5608, 1'b0, 1'b0, 3'd2, 64'h0000_0000_1234_5600, 1'b1, 4'd10}, // R10
        '{3'd2, 32'hAB00_00FF, 4'h8, 32'hAB34_5608, 1'b1, 1'b0, 3'd2, 64'h0000_0000_AB34_5600, 1'b1, 4'd2},  // R2 bytes
        '{3'd2, 32'h0000_0077, 4'hF, 32'h0000_0008, 1'b0, 1'b0, 3'd2, 64'h0000_0000_AB34_5600, 1'b1, 4'd9},  // R9
        '{3'd0, 32'h89AB_CDEF, 4'hF, 32'h89AB_C004, 1'b1, 1'b0, 3'd0, 64'h0000_0000_89AB_C000, 1'b1, 4'd5},  // R5
        '{3'd1, 32'h0000_0012, 4'hF, 32'h0000_0012, 1'b1, 1'b0, 3'd0, 64'h0000_0012_89AB_C000, 1'b1, 4'd4},  // R4
        '{3'd1, 32'h0000_0034, 4'hF, 32'h0000_0034, 1'b1, 1'b0, 3'd0, 64'h0000_0034_89AB_C000, 1'b1, 4'd4},  // R4
        '{3'd0, 32'h5555_5555, 4'hF, 32'h5555_5004, 1'b1, 1'b0, 3'd0, 64'h0000_0034_5555_5000, 1'b1, 4'd5},  // R5
        '{3'd4, 32'hFFFF_FFFF, 4'hF, 32'hFFFF_0006, 1'b1, 1'b0, 3'd4, 64'h0000_0000_FFFF_0000, 1'b1, 4'd7},  // R7
        '{3'd3, 32'h0000_ABCD, 4'hF, 32'h0000_ABC1, 1'b1, 1'b0, 3'd3, 64'h0000_0000_0000_ABC0, 1'b1, 4'd8},  // R8
        '{3'd5, 32'h0000_1234, 4'hF, 32'h0000_1201, 1'b1, 1'b1, 3'd5, 64'h0000_0000_0000_1200, 1'b1, 4'd8},  // R8
        '{3'd6, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000, 1'b0, 1'b0, 3'd2, 64'h0000_0000_AB34_5600, 1'b1, 4'd11}  // R11
    };

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one write at a falling edge; return at the falling edge after
    // the capturing rising edge, where registered outputs are settled.
    task automatic do_write(input logic [2:0] idx, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d; wr_be = be; rd_idx = idx;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [63:0] slot(input int s);
        return dec_base[s*64 +: 64];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] ro_exp [6];
        ro_exp = '{32'h4, 32'h0, 32'h8, 32'h1, 32'h6, 32'h1};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of read-back, bases, flags and pulses
        for (int i = 0; i < 6; i++) begin
            rd_idx = 3'(i);
            #1;
            check("R1", "reset read-back", 64'(rd_data), 64'(ro_exp[i]));
            check("R1", "reset base", slot(i), 64'h0);
        end
        check("R1", "reset valid", 64'(dec_valid), 64'h0);
        check("R1", "reset pulse", 64'(range_chg), 64'h0);

        // Table walk
        for (int r = 0; r < 13; r++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[r].req);
            do_write(VEC[r].widx, VEC[r].data, VEC[r].be);
            check(tag, "read-back", 64'(rd_data), 64'(VEC[r].rb));
            check(tag, "range pulse", 64'(range_chg), 64'(VEC[r].pulse));
            check(tag, "io error", 64'(io_wide_err), 64'(VEC[r].err));
            check(tag, "base", slot(int'(VEC[r].slot)), VEC[r].dec);
            check(tag, "valid", 64'(dec_valid[VEC[r].slot]), 64'(VEC[r].val));
        end

        // R6: upper half slot never reports a range
        check("R6", "upper slot base", slot(1), 64'h0);
        check("R6", "upper slot valid", 64'(dec_valid[1]), 64'h0);

        // R3: pulse lasts one cycle
        do_write(3'd2, 32'h0000_4400, 4'hF);
        check("R3", "pulse high", 64'(range_chg), 64'h1);
        @(negedge clk);
        check("R3", "pulse low next cycle", 64'(range_chg), 64'h0);

        // R1: mid-run reset clears everything
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_idx = 3'd0;
        #1;
        check("R1", "post-reset read-back", 64'(rd_data), 64'h4);
        check("R1", "post-reset base", slot(0), 64'h0);
        check("R1", "post-reset valid", 64'(dec_valid), 64'h0);

        // R4 then R5: upper half first into a clean pair
        do_write(3'd1, 32'h0000_0077, 4'hF);
        check("R4", "upper-first base", slot(0), 64'h0000_0077_0000_0000);
        check("R4", "upper-first valid", 64'(dec_valid[0]), 64'h1);
        check("R4", "upper-first pulse", 64'(range_chg), 64'h1);
        check("R6", "upper slot after write", slot(1), 64'h0);
        do_write(3'd0, 32'h0000_2ABC, 4'hF);
        check("R5", "low-last base", slot(0), 64'h0000_0077_0000_2000);
        check("R5", "low-last pulse", 64'(range_chg), 64'h1);

        // R9: zero write to the upper half leaves the pair's base alone
        do_write(3'd1, 32'h0000_0000, 4'hF);
        check("R9", "zero upper read-back", 64'(rd_data), 64'h0);
        check("R9", "zero upper base", slot(0), 64'h0000_0077_0000_2000);
        check("R9", "zero upper pulse", 64'(range_chg), 64'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule